// File: doc/BRIEF.md
# Reloading Down-Count System Timer

This block is a 32-bit count-down timer for operating-system time keeping. Software writes a start value into a preset register, then sets a run bit in the control register. The count then falls by one on every tick from the chosen tick source. When the count reaches zero the block raises a one-cycle `zero_pulse`. What happens next depends on a mode bit. Either the count is refilled from the preset register and keeps going, or the timer halts at zero and clears its own run bit.

Two tick sources are offered as single-cycle enables in the system clock domain: a reference tick and a PLL-derived tick. One control bit picks between them. The count can be read while the timer runs or after it stops, through two views. The first is a wide view that returns all 32 bits in one read. The second is a narrow 16-bit view. Reading its upper half also latches the lower half of the same count into a holding register. A following lower-half read then returns that latched value, so a pair of narrow reads always gives one coherent 32-bit value.

All access goes through a simple synchronous register bus. Read data appears one cycle after the read enable.

Top module: `os_down_timer`

## Requirements
- R1: After reset, the control register reads 4: bit 0 (run) is 0, bit 1 (refill mode) is 0 and bit 2 (source select) is 1. The count reads 0, the lower-half holding register reads 0 and `zero_pulse` is low.
- R2: A control write (address 0) that sets bit 0 while the run bit is 0 copies the preset register (address 1) into the count.
- R3: While the run bit is 1 and the count is nonzero, each selected tick lowers the count by exactly one. A tick from the source that is not selected has no effect.
- R4: Source select 0 takes ticks from `ref_tick` and source select 1 takes them from `pll_tick`.
- R5: With refill mode set, a selected tick that arrives while the count is 0 loads the count from the preset register and the timer keeps running.
- R6: With refill mode clear, the tick that brings the count to 0 also clears the run bit. The same applies to a selected tick that arrives while the count is already 0. After that the count stays at 0.
- R7: `zero_pulse` is high for one cycle. It is high in the cycle after each consumed tick whose resulting count is 0, and low at all other times.
- R8: While the run bit is 0, ticks leave the count unchanged. Clearing the run bit freezes the count at its current value.
- R9: A read of address 2 returns the full 32-bit count, sampled in the read-enable cycle, on `bus_rdata` one cycle later.
- R10: A read of address 3 returns count bits 31:16 on `bus_rdata[15:0]`, with the upper bits zero. In the same cycle it copies count bits 15:0 into the holding register.
- R11: A read of address 4 returns the holding register on `bus_rdata[15:0]`, not the live count.
- R12: In a cycle with a control write, any tick is ignored. The written run, mode and select bits take effect from the next cycle.
- R13: Reads of any unused address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_re` |
| ref_tick | input | 1 | Reference count enable |
| pll_tick | input | 1 | PLL-derived count enable |
| zero_pulse | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The main counting function is exercised with several tick patterns:
- **Pulses on one source only.** These separate a correct source select from a swapped one.
- **Dense ticks on both sources at once.** These show whether the source that is not selected leaks into the count.
- **Ticks that coincide with control writes.** These show the write taking priority over the tick.
- **A pseudo-random mix of ticks, reads and mode changes.** This covers combinations the scripted cases miss.

A few sequences target specific corners:
- A refill run with preset 0 separates "pulse on every tick" from "pulse once".
- A halt run separates stopping at zero from wrapping to all ones.
- A preset of 0x00020001, read upper half first and lower half after two ticks, separates a latched lower half from a live one.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_LOAD = 3'd1,
      REG_FULL = 3'd2,
      REG_HI   = 3'd3,
      REG_LO   = 3'd4
   } reg_addr_e;

   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_RLD_BIT = 1;
   localparam int unsigned CTRL_SEL_BIT = 2;
endpackage

// File: rtl/ostmr_tick_sel.sv
module ostmr_tick_sel (
   input  logic sel,
   input  logic ref_tick,
   input  logic pll_tick,
   output logic tick
);
   assign tick = sel ? pll_tick : ref_tick;
endmodule

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_now,
   input  logic             step,
   input  logic             reload_mode,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             zero_pulse,
   output logic             stop_req
);
   logic [CNT_W-1:0] next_val;
   logic             at_zero;

   assign at_zero  = (count == '0);
   assign next_val = at_zero ? (reload_mode ? load_val : '0) : count - 1'b1;
   assign stop_req = step && !reload_mode && (next_val == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count      <= '0;
         zero_pulse <= 1'b0;
      end else begin
         zero_pulse <= 1'b0;
         if (load_now) begin
            count <= load_val;
         end else if (step) begin
            count      <= next_val;
            zero_pulse <= (next_val == '0);
         end
      end
   end
endmodule

// File: rtl/ostmr_snap.sv
module ostmr_snap #(
   parameter int unsigned HALF_W     = 16,
   parameter bit          HAS_NARROW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [HALF_W-1:0] low_in,
   output logic [HALF_W-1:0] held
);
   generate
      if (HAS_NARROW) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)       held <= '0;
            else if (capture) held <= low_in;
         end
      end else begin : g_nohold
         assign held = '0;
      end
   endgenerate
endmodule

// File: rtl/os_down_timer.sv
module os_down_timer #(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned HALF_W      = 16,
   parameter bit          SEL_RST     = 1'b1,
   parameter bit          HAS_NARROW  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic             bus_we,
   input  logic             bus_re,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             ref_tick,
   input  logic             pll_tick,
   output logic             zero_pulse
);
   import ostmr_pkg::*;

   localparam int unsigned PAD_W = CNT_W - HALF_W;

   generate
      if (CNT_W != 2 * HALF_W) begin : g_bad_width
         $error("CNT_W must be twice HALF_W");
      end
      if (CNT_W < 4) begin : g_bad_small
         $error("CNT_W too small");
      end
   endgenerate

   logic             start_q, ar_q, sel_q;
   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] cnt_q;
   logic [HALF_W-1:0] hold_q;
   logic             tick_sel, ctrl_wr, load_wr, load_now, step, stop_req;
   reg_addr_e        addr;

   assign addr     = reg_addr_e'(bus_addr);
   assign ctrl_wr  = bus_we && (addr == REG_CTRL);
   assign load_wr  = bus_we && (addr == REG_LOAD);
   assign load_now = ctrl_wr && bus_wdata[CTRL_RUN_BIT] && !start_q;
   assign step     = start_q && tick_sel && !ctrl_wr;

   ostmr_tick_sel u_sel (
      .sel      (sel_q),
      .ref_tick (ref_tick),
      .pll_tick (pll_tick),
      .tick     (tick_sel)
   );

   ostmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_now    (load_now),
      .step        (step),
      .reload_mode (ar_q),
      .load_val    (load_q),
      .count       (cnt_q),
      .zero_pulse  (zero_pulse),
      .stop_req    (stop_req)
   );

   ostmr_snap #(.HALF_W(HALF_W), .HAS_NARROW(HAS_NARROW)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (bus_re && (addr == REG_HI)),
      .low_in  (cnt_q[HALF_W-1:0]),
      .held    (hold_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         ar_q    <= 1'b0;
         sel_q   <= SEL_RST;
         load_q  <= '0;
      end else begin
         if (load_wr) load_q <= bus_wdata;
         if (ctrl_wr) begin
            start_q <= bus_wdata[CTRL_RUN_BIT];
            ar_q    <= bus_wdata[CTRL_RLD_BIT];
            sel_q   <= bus_wdata[CTRL_SEL_BIT];
         end else if (stop_req) begin
            start_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_re) begin
         case (addr)
            REG_CTRL: bus_rdata <= {{(CNT_W-3){1'b0}}, sel_q, ar_q, start_q};
            REG_LOAD: bus_rdata <= load_q;
            REG_FULL: bus_rdata <= cnt_q;
            REG_HI:   bus_rdata <= {{PAD_W{1'b0}}, cnt_q[CNT_W-1 -: HALF_W]};
            REG_LO:   bus_rdata <= {{PAD_W{1'b0}}, hold_q};
            default:  bus_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned HALF_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  load,
   input logic [HALF_W-1:0] hold,
   input logic              start,
   input logic              ar,
   input logic              tick,
   input logic              ctrl_wr,
   input logic              snap_rd,
   input logic              zero_pulse
);
   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (start && tick && !ctrl_wr && count != '0) |=> (count == $past(count) - 1'b1));

   a_r5_refill: assert property (@(posedge clk) disable iff (!rst_n)
      (start && tick && !ctrl_wr && ar && count == '0) |=> (count == $past(load)));

   a_r6_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (start && tick && !ctrl_wr && !ar && count <= 1) |=> (!start && count == '0));

   a_r7_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      zero_pulse |-> (count == '0));

   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !ctrl_wr) |=> $stable(count));

   a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
      snap_rd |=> (hold == $past(count[HALF_W-1:0])));
endmodule

bind os_down_timer ostmr_chk #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .count      (cnt_q),
   .load       (load_q),
   .hold       (hold_q),
   .start      (start_q),
   .ar         (ar_q),
   .tick       (tick_sel),
   .ctrl_wr    (ctrl_wr),
   .snap_rd    (bus_re && (bus_addr == 3'd3)),
   .zero_pulse (zero_pulse)
);

// File: tb/sim_os_down_timer.sv
module sim_os_down_timer;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ref_tick = 1'b0, pll_tick = 1'b0;
   logic        zero_pulse;

   os_down_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ref_tick(ref_tick), .pll_tick(pll_tick), .zero_pulse(zero_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    vectors = 0;
   int    fails   = 0;
   int    cycles  = 0;
   bit    done    = 0;
   string cur_req = "R1";

   // behavioural model state
   bit          m_run, m_rld, m_sel;
   logic [31:0] m_load, m_cnt;
   logic [15:0] m_hold;
   logic [31:0] e_rdata;
   bit          e_rvalid, e_pulse;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_run = 0; m_rld = 0; m_sel = 1; m_load = 0; m_cnt = 0; m_hold = 0;
      e_rdata = 0; e_rvalid = 0; e_pulse = 0;
   endtask

   // one clock: compare previous expectations, drive, predict
   task automatic step(logic [2:0] a, bit we, bit re, logic [31:0] wd, bit rt, bit pt);
      bit tick, cwr;
      logic [31:0] res;
      bit n_run, n_rld, n_sel;
      logic [31:0] n_load, n_cnt;
      logic [15:0] n_hold;
      @(negedge clk);
      check(cur_req, {31'd0, zero_pulse}, {31'd0, e_pulse}, "zero_pulse");
      if (e_rvalid) check(cur_req, bus_rdata, e_rdata, "rdata");
      bus_addr = a; bus_we = we; bus_re = re; bus_wdata = wd;
      ref_tick = rt; pll_tick = pt;
      n_run = m_run; n_rld = m_rld; n_sel = m_sel;
      n_load = m_load; n_cnt = m_cnt; n_hold = m_hold;
      e_rvalid = re;
      if (re) begin
         case (a)
            3'd0: e_rdata = {29'd0, m_sel, m_rld, m_run};
            3'd1: e_rdata = m_load;
            3'd2: e_rdata = m_cnt;
            3'd3: begin e_rdata = {16'd0, m_cnt[31:16]}; n_hold = m_cnt[15:0]; end
            3'd4: e_rdata = {16'd0, m_hold};
            default: e_rdata = 0;
         endcase
      end
      tick = m_sel ? pt : rt;
      cwr  = we && (a == 3'd0);
      e_pulse = 0;
      if (we && a == 3'd1) n_load = wd;
      if (cwr) begin
         if (wd[0] && !m_run) n_cnt = m_load;
         n_run = wd[0]; n_rld = wd[1]; n_sel = wd[2];
      end else if (m_run && tick) begin
         if (m_cnt == 0) res = m_rld ? m_load : 0;
         else            res = m_cnt - 1;
         n_cnt = res;
         e_pulse = (res == 0);
         if (!m_rld && res == 0) n_run = 0;
      end
      m_run = n_run; m_rld = n_rld; m_sel = n_sel;
      m_load = n_load; m_cnt = n_cnt; m_hold = n_hold;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(3'd0, 0, 0, 0, 0, 0);
   endtask
   task automatic wr(logic [2:0] a, logic [31:0] d);
      step(a, 1, 0, d, 0, 0);
   endtask
   task automatic rd(logic [2:0] a);
      step(a, 0, 1, 0, 0, 0);
   endtask
   task automatic ticks(int n, bit rt, bit pt);
      for (int i = 0; i < n; i++) step(3'd0, 0, 0, 0, rt, pt);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values; R11 low half before any upper read is zero
      cur_req = "R1";
      rd(3'd0); rd(3'd2); rd(3'd4); rd(3'd1);
      cur_req = "R13"; rd(3'd5); rd(3'd7);

      // R2 start loads preset; R9 full read
      cur_req = "R2";
      wr(3'd1, 32'd5);
      wr(3'd0, 32'h5);
      cur_req = "R9"; rd(3'd2); rd(3'd1);

      // R3/R4 pll selected: ref ticks ignored
      cur_req = "R4";
      ticks(3, 1, 0); rd(3'd2);
      cur_req = "R3";
      ticks(2, 0, 1); rd(3'd2);
      ticks(2, 1, 1); rd(3'd2);

      // R6/R7 halt at zero, run self-clears
      cur_req = "R6";
      ticks(1, 0, 1); rd(3'd0); rd(3'd2);
      cur_req = "R7";
      ticks(3, 0, 1); rd(3'd2); rd(3'd0);

      // R5 refill mode, period preset+1
      cur_req = "R5";
      wr(3'd1, 32'd3);
      wr(3'd0, 32'h7);
      for (int i = 0; i < 10; i++) begin
         step(3'd2, 0, 1, 0, 0, 1);
      end

      // R12 control write with tick: tick ignored
      cur_req = "R12";
      step(3'd0, 1, 0, 32'h7, 1, 1);
      rd(3'd2);

      // R8 freeze
      cur_req = "R8";
      wr(3'd0, 32'h6);
      ticks(4, 1, 1); rd(3'd2); rd(3'd0);

      // R4 reference source, refill, pll ignored
      cur_req = "R4";
      wr(3'd1, 32'd2);
      wr(3'd0, 32'h3);
      ticks(3, 0, 1); rd(3'd2);
      ticks(5, 1, 0); rd(3'd2);

      // R7 refill with preset 0: pulse on every tick
      cur_req = "R7";
      wr(3'd0, 32'h0);
      wr(3'd1, 32'd0);
      wr(3'd0, 32'h3);
      ticks(4, 1, 0);
      step(3'd0, 0, 0, 0, 1, 0); idle(2);

      // R10/R11 coherent narrow pair across half boundary
      cur_req = "R10";
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h0002_0001);
      wr(3'd0, 32'h1);
      rd(3'd3);
      ticks(2, 1, 0);
      cur_req = "R11";
      rd(3'd4); rd(3'd2);
      cur_req = "R10";
      rd(3'd3); rd(3'd4);

      // mixed pseudo-random traffic
      cur_req = "R3";
      wr(3'd1, 32'd6);
      wr(3'd0, 32'h7);
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[7:4] == 4'hF)
            step(3'd0, 1, 0, {29'd0, lfsr[2], lfsr[1], lfsr[0] | lfsr[3]}, lfsr[8], lfsr[9]);
         else
            step({1'b0, lfsr[11:10]} + {2'b0, lfsr[12]}, 0, lfsr[13], 0, lfsr[8], lfsr[9]);
      end
      idle(2);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule